// File: doc/BRIEF.md
# Quadrature Sine Test Tone Source

This block produces an endless complex test tone for a 12-bit DAC datapath without any memory traffic. One sine period is stored as 32 signed 12-bit values that are decoded from a quarter-wave set in logic. Two phase indices walk through that period, one for the in-phase channel and one for the quadrature channel. The quadrature index runs a quarter period ahead, so the Q channel carries the cosine while the I channel carries the sine.

Each sample is placed in the top twelve bits of its own 16-bit lane. The two lanes form one 32-bit word, which is offered with a valid/ready handshake. A word advances only when the consumer accepts it. The tone period is 64 accepted words because every table entry is used for two consecutive samples.

Top module: `iq_tone_gen`

## Requirements
- R1: While `rst` is high, and for the first clock cycle after it falls, `tone_valid` is low. The first word accepted after reset is sample number 0 of the sequence.
- R2: Once `tone_valid` has risen, it stays high until the next reset.
- R3: The period table holds 32 signed 12-bit entries. Entries 0 to 8 are 0x000, 0x031, 0x061, 0x08D, 0x0B4, 0x0D4, 0x0EC, 0x0FA and 0x0FF. For k in 9 to 15, entry k equals entry 16−k. Entry 16 is 0x000. For k in 17 to 31, entry k is the bitwise complement of entry k−16 (for example entry 17 is 0xFCE and entry 24 is 0xF00).
- R4: Accepted word number n carries I sample table[(n mod 64)/2], so every table entry appears in two consecutive words.
- R5: Bits [31:20] hold the I sample and bits [15:4] hold the Q sample. Bits [19:16] and [3:0] are zero.
- R6: The Q sample of word n equals table[((n+16) mod 64)/2], a quarter period ahead of I. After reset and before any transfer, the word is 0x00000FF0.
- R7: The sequence advances by exactly one word on each cycle where `tone_valid` and `tone_ready` are both high. While `tone_valid` is high and `tone_ready` is low, `tone_word` does not change.
- R8: The sequence wraps after 64 words, so word 64 equals word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tone_ready | input | 1 | Consumer accepts the current word |
| tone_valid | output | 1 | A word is on offer |
| tone_word | output | 32 | I lane in bits [31:16], Q lane in bits [15:0], each left-justified |

## Verification
The consumer first accepts every cycle for more than two full periods. This separates correct wrapping (R8) and entry doubling (R4) from off-by-one index faults, and it checks every table value in both lanes. An alternating ready pattern and a random one then show whether the index advances on stalls, and whether the word stays stable while it is held. A reset in the middle of a run must restart at sample 0 with the quadrature lead intact. This catches a start value that is kept or lost on either channel.

// File: rtl/iq_tone_pkg.sv
package iq_tone_pkg;
    localparam int SAMPLE_W = 12;
    localparam int LANE_W   = 16;
    localparam int CHANNELS = 2;
    localparam int PAD_W    = LANE_W - SAMPLE_W;

    // Place a signed sample in the top of its lane and zero the low bits.
    function automatic logic [LANE_W-1:0] justify(input logic [SAMPLE_W-1:0] s);
        return {s, {PAD_W{1'b0}}};
    endfunction
endpackage

// File: rtl/iq_sine_rom.sv
module iq_sine_rom #(
    parameter int ADDR_W   = 5,
    parameter int SAMPLE_W = 12
) (
    input  logic [ADDR_W-1:0]   addr,
    output logic [SAMPLE_W-1:0] sample
);
    localparam int HALF_W = ADDR_W - 1;
    localparam int HALF_N = 1 << HALF_W;
    localparam int QTR_N  = 1 << (ADDR_W - 2);

    logic              neg_half;
    logic [HALF_W-1:0] pos;
    logic [HALF_W-1:0] fold;
    logic [SAMPLE_W-1:0] mag;

    always_comb begin
        neg_half = addr[ADDR_W-1];
        pos      = addr[HALF_W-1:0];
        if (int'(pos) <= QTR_N) fold = pos;
        else                    fold = HALF_W'(HALF_N - int'(pos));
    end

    // Quarter-wave magnitudes, indices 0 through the peak.
    always_comb begin
        case (fold)
            HALF_W'(0): mag = SAMPLE_W'(12'h000);
            HALF_W'(1): mag = SAMPLE_W'(12'h031);
            HALF_W'(2): mag = SAMPLE_W'(12'h061);
            HALF_W'(3): mag = SAMPLE_W'(12'h08D);
            HALF_W'(4): mag = SAMPLE_W'(12'h0B4);
            HALF_W'(5): mag = SAMPLE_W'(12'h0D4);
            HALF_W'(6): mag = SAMPLE_W'(12'h0EC);
            HALF_W'(7): mag = SAMPLE_W'(12'h0FA);
            default:    mag = SAMPLE_W'(12'h0FF);
        endcase
    end

    always_comb begin
        if (!neg_half)       sample = mag;
        else if (pos == '0)  sample = '0;
        else                 sample = ~mag;
    end
endmodule

// File: rtl/iq_phase_reg.sv
module iq_phase_reg #(
    parameter int PHASE_W = 6,
    parameter int START   = 0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               adv,
    output logic [PHASE_W-1:0] idx
);
    typedef struct packed {
        logic [PHASE_W-1:0] idx;
    } ph_t;

    ph_t ph_d, ph_q;

    always_comb begin
        ph_d = ph_q;
        if (adv) ph_d.idx = ph_q.idx + 1'b1;
        if (rst) ph_d.idx = PHASE_W'(START);
    end

    always_ff @(posedge clk) begin
        ph_q <= ph_d;
    end

    assign idx = ph_q.idx;

    // R7
    adv_step_chk: assert property (@(posedge clk) disable iff (rst)
        adv |=> (ph_q.idx == PHASE_W'($past(ph_q.idx) + 1'b1)));
endmodule

// File: rtl/iq_tone_gen.sv
module iq_tone_gen
    import iq_tone_pkg::*;
#(
    parameter int PHASE_W = 6
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       tone_ready,
    output logic                       tone_valid,
    output logic [CHANNELS*LANE_W-1:0] tone_word
);
    localparam int ADDR_W = PHASE_W - 1;
    localparam int Q_LEAD = 1 << (PHASE_W - 2);

    typedef struct packed {
        logic valid;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic adv;
    logic [PHASE_W-1:0]  idx   [CHANNELS];
    logic [SAMPLE_W-1:0] smp   [CHANNELS];

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.valid = 1'b1;
        if (rst) ctl_d.valid = 1'b0;
    end

    always_ff @(posedge clk) begin
        ctl_q <= ctl_d;
    end

    assign tone_valid = ctl_q.valid;
    assign adv        = ctl_q.valid && tone_ready;

    // Channel 0 is I (upper lane), channel 1 is Q (lower lane).
    for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_lane
        iq_phase_reg #(
            .PHASE_W(PHASE_W),
            .START  ((ch == 0) ? 0 : Q_LEAD)
        ) u_phase (
            .clk(clk),
            .rst(rst),
            .adv(adv),
            .idx(idx[ch])
        );

        iq_sine_rom #(
            .ADDR_W  (ADDR_W),
            .SAMPLE_W(SAMPLE_W)
        ) u_rom (
            .addr  (idx[ch][PHASE_W-1:1]),
            .sample(smp[ch])
        );

        assign tone_word[(CHANNELS-ch)*LANE_W-1 -: LANE_W] = justify(smp[ch]);
    end

    // R2
    valid_hold_chk: assert property (@(posedge clk) disable iff (rst)
        tone_valid |=> tone_valid);

    // R6
    quad_lead_chk: assert property (@(posedge clk) disable iff (rst)
        PHASE_W'(idx[1] - idx[0]) == PHASE_W'(Q_LEAD));

    // R7
    stall_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (tone_valid && !tone_ready) |=> $stable(tone_word));
endmodule

// File: tb/iq_tone_gen_test.sv
`timescale 1ns/1ps
module iq_tone_gen_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tone_ready = 1'b0;
    logic        tone_valid;
    logic [31:0] tone_word;

    int checks = 0;
    int failures = 0;
    int accepted = 0;
    logic [31:0] exp_q [$];
    logic [11:0] tbl [32];

    always #2 clk = ~clk;

    iq_tone_gen uut (
        .clk       (clk),
        .rst       (rst),
        .tone_ready(tone_ready),
        .tone_valid(tone_valid),
        .tone_word (tone_word)
    );

    // R3: literal table from the requirement.
    initial begin
        tbl = '{12'h000, 12'h031, 12'h061, 12'h08D, 12'h0B4, 12'h0D4, 12'h0EC, 12'h0FA,
                12'h0FF, 12'h0FA, 12'h0EC, 12'h0D4, 12'h0B4, 12'h08D, 12'h061, 12'h031,
                12'h000, 12'hFCE, 12'hF9E, 12'hF72, 12'hF4B, 12'hF2B, 12'hF13, 12'hF05,
                12'hF00, 12'hF05, 12'hF13, 12'hF2B, 12'hF4B, 12'hF72, 12'hF9E, 12'hFCE};
    end

    function automatic logic [31:0] model(input int n);
        return {tbl[(n % 64) / 2], 4'h0, tbl[((n + 16) % 64) / 2], 4'h0};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Driver side of the scoreboard: expected words from sample 0 on.
    task automatic push_expected(input int count);
        for (int n = 0; n < count; n++) exp_q.push_back(model(n));
    endtask

    // Monitor: compare each accepted word, and watch for stalls.
    logic [31:0] prev_word;
    bit          prev_hold = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (prev_hold)
                check(tone_word == prev_word, "R7 stall stability", tone_word, prev_word);
            if (tone_valid && tone_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4 scoreboard empty", tone_word, 32'h0);
                end else begin
                    logic [31:0] e;
                    e = exp_q.pop_front();
                    // R3 R4 R5 R6 R8
                    check(tone_word == e, "R3/R4/R5/R6/R8 word", tone_word, e);
                    accepted++;
                end
            end
            prev_hold = tone_valid && !tone_ready;
            prev_word = tone_word;
        end else begin
            prev_hold = 1'b0;
        end
    end

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
        summary();
        $finish;
    end

    task automatic apply_reset;
        @(posedge clk); #1;
        rst = 1'b1;
        tone_ready = 1'b0;
        exp_q.delete();
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R1, R6: state during reset
        check(tone_valid == 1'b0, "R1 valid low in reset", {31'h0, tone_valid}, 32'h0);
        check(tone_word == 32'h00000FF0, "R6 reset word", tone_word, 32'h00000FF0);
        push_expected(400);
        @(posedge clk); #1;
        rst = 1'b0;
        tone_ready = 1'b1;
        @(negedge clk);
        check(tone_valid == 1'b0, "R1 valid low one cycle", {31'h0, tone_valid}, 32'h0);
        @(negedge clk);
        check(tone_valid == 1'b1, "R2 valid rises", {31'h0, tone_valid}, 32'h1);
    endtask

    initial begin
        int base;
        apply_reset();
        // Pattern A: ready always high, over two periods (R4, R8).
        repeat (140) @(posedge clk);
        // Pattern B: alternating ready (R7).
        for (int i = 0; i < 60; i++) begin
            @(posedge clk); #1;
            tone_ready = i[0];
        end
        // Pattern C: random ready (R7).
        for (int i = 0; i < 120; i++) begin
            @(posedge clk); #1;
            tone_ready = 1'($urandom);
        end
        @(posedge clk); #1;
        tone_ready = 1'b0;
        @(negedge clk);
        check(tone_valid == 1'b1, "R2 valid stays high", {31'h0, tone_valid}, 32'h1);
        base = accepted;
        check(base > 200, "R7 transfers made", base, 32'd200);
        // Mid-run reset, restart from sample 0 (R1).
        apply_reset();
        repeat (40) @(posedge clk);
        @(negedge clk);
        check(accepted - base >= 40, "R1 restart transfers", accepted - base, 32'd40);
        summary();
        $finish;
    end
endmodule